// File: doc/BRIEF.md
# Interrupt Dispatch and Fault Escalation

This block sits at the point where an interrupt or exception request becomes a dispatch decision. A request carries an 8-bit vector, a source class, a cause bit for the debug vector and a candidate error code. The block tests the request against the interrupt table limit and decides one of three outcomes. The request is dispatched as asked, or it is replaced by a double fault, or a shutdown bus cycle is signalled. For a request that is dispatched, it reports three more things. It reports whether an error code goes on the stack and what value that code has. It also reports whether the handler returns to the faulting instruction or to the one after it.

The request side and the dispatch side are both valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block has no result waiting, so one request is in flight at a time. The result appears on the cycle after acceptance with `disp_valid` high. It stays stable through back-pressure until `disp_ready` is seen high on a clock edge. Shutdown is terminal. No result is produced for the request that caused it, and the block takes nothing further until its reset is asserted.

Top module: `ixd_dispatch`

## Requirements
- R1: `req_ready` is high exactly when no result is pending and the block is not shut down. A result is presented with `disp_valid` on the cycle after acceptance. While `disp_ready` is low, `disp_valid` and every result field hold unchanged. A result is consumed on a clock edge where `disp_ready` is high, and `req_ready` returns high after that edge.
- R2: A request whose vector satisfies vector*8+7 <= `idt_limit` is dispatched with its own vector and `disp_status` = 0 (first attempt).
- R3: A request that fails that test is dispatched as vector 8 with `disp_status` = 1 (double fault). This holds whatever its vector and class. The replacement is an abort: `disp_restart` = 0, and in protected mode an error code of zero is pushed.
- R4: When both the request and vector 8 fail the test, no result is presented. Instead `shutdown_strobe` pulses high for exactly one cycle, on the cycle after acceptance, and `disp_status` becomes 2 (shutdown).
- R5: After shutdown, `req_ready` and `disp_valid` stay low and requests are ignored until `rst_n` is asserted. After reset, dispatch works normally again.
- R6: `req_class` encodes the source: 00 is a software interrupt, 01 is an external interrupt, and 1x is a processor exception. Only the exception class can push an error code. In protected mode (`prot_mode` = 1) it does so for vectors 8, 10, 11, 12, 13, 14 and 17. The pushed value is `req_err_code`, except for vector 8, which pushes zero.
- R7: In real mode (`prot_mode` = 0), `disp_push_err` is 0 and `disp_err_code` is 0 for every vector and class. `disp_err_code` is also 0 whenever nothing is pushed.
- R8: `disp_restart` is 1 only for exception-class faults. For the exception class, vectors 2, 3 and 4 are traps and vectors 8 and 18 are aborts, and all of these give 0. Every other vector of the exception class is a fault. Software and external interrupts give 0.
- R9: For the exception class, vector 1 is a fault (`disp_restart` = 1) when `req_code_bp` = 1 and a trap (`disp_restart` = 0) when `req_code_bp` = 0.
- R10: With `idt_limit` = 0x80, vectors 0 to 15 dispatch as first attempts and vector 16 or higher becomes a double fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idt_limit | input | 16 | Interrupt table limit in bytes, sampled at acceptance |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_vector | input | 8 | Requested vector |
| req_class | input | 2 | 00 software, 01 external, 1x exception |
| req_code_bp | input | 1 | Vector 1 cause: 1 = code breakpoint (fault), 0 = trap |
| req_err_code | input | 16 | Error code offered by the exception source |
| disp_valid | output | 1 | Dispatch result present |
| disp_ready | input | 1 | Consumer takes the result |
| disp_vector | output | 8 | Vector actually dispatched |
| disp_push_err | output | 1 | An error code is pushed |
| disp_err_code | output | 16 | Error code value to push |
| disp_restart | output | 1 | Return address is the faulting instruction |
| disp_status | output | 2 | 0 first attempt, 1 double fault, 2 shutdown |
| shutdown_strobe | output | 1 | One-cycle shutdown bus cycle request |

## Verification
The assertions assume two things about the inputs. First, `disp_ready` is a plain level that the consumer drives without regard to `disp_valid`. Second, `rst_n` is the only way out of shutdown. Nothing is assumed about `req_valid` while `req_ready` is low, because such requests are dropped. In the random phase, limits are drawn no lower than 71, so vector 8 always fits and shutdown comes only from the directed cases that end with a reset. Vectors are biased toward 0 to 20 so that every class decode is hit, and classes, modes, cause bits and back-pressure lengths are mixed freely.

// File: rtl/ixd_pkg.sv
`timescale 1ns/1ps
package ixd_pkg;
  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_DOUBLE = 2'd1,
    ST_SHUT   = 2'd2
  } disp_status_e;

  typedef enum logic [1:0] {
    K_TRAP  = 2'd0,
    K_FAULT = 2'd1,
    K_ABORT = 2'd2
  } event_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HOLD = 2'd1,
    S_HALT = 2'd2
  } ctl_state_e;

  localparam logic [1:0] CLS_EXCEPTION = 2'b10;
endpackage

// File: rtl/ixd_limit_chk.sv
`timescale 1ns/1ps
module ixd_limit_chk #(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  parameter int SHIFT = 3
) (
  input  logic [VEC_W-1:0] vector,
  input  logic [LIM_W-1:0] limit,
  output logic             fits
);
  localparam int ENTRY_W = VEC_W + SHIFT;
  localparam int EXT_W   = (ENTRY_W > LIM_W) ? ENTRY_W + 1 : LIM_W + 1;

  logic [EXT_W-1:0] last_byte;
  logic [EXT_W-1:0] limit_x;

  // last byte of the gate entry must lie inside the table
  always_comb begin
    last_byte = EXT_W'({vector, {SHIFT{1'b1}}});
    limit_x   = EXT_W'(limit);
    fits      = (last_byte <= limit_x);
  end
endmodule

// File: rtl/ixd_classify.sv
`timescale 1ns/1ps
module ixd_classify
  import ixd_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] vector,
  input  logic [1:0]       src_class,
  input  logic             code_bp,
  input  logic             prot_mode,
  output logic             push_err,
  output logic             restart,
  output logic             is_abort
);
  event_kind_e kind;
  logic        code_vec;
  logic        is_exc;

  always_comb begin
    is_exc = src_class[1];
    case (int'(vector))
      1:       kind = code_bp ? K_FAULT : K_TRAP;
      2, 3, 4: kind = K_TRAP;
      8, 18:   kind = K_ABORT;
      default: kind = K_FAULT;
    endcase
    if (!is_exc) kind = K_TRAP;

    case (int'(vector))
      8, 10, 11, 12, 13, 14, 17: code_vec = 1'b1;
      default:                   code_vec = 1'b0;
    endcase

    push_err = is_exc && code_vec && prot_mode;
    restart  = (kind == K_FAULT);
    is_abort = (kind == K_ABORT);
  end
endmodule

// File: rtl/ixd_dispatch.sv
`timescale 1ns/1ps
module ixd_dispatch
  import ixd_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int LIM_W  = 16,
  parameter int ERR_W  = 16,
  parameter int SHIFT  = 3,
  parameter int DF_VEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] idt_limit,
  input  logic             prot_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vector,
  input  logic [1:0]       req_class,
  input  logic             req_code_bp,
  input  logic [ERR_W-1:0] req_err_code,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic [VEC_W-1:0] disp_vector,
  output logic             disp_push_err,
  output logic [ERR_W-1:0] disp_err_code,
  output logic             disp_restart,
  output logic [1:0]       disp_status,
  output logic             shutdown_strobe
);
  localparam int NCAND = 2;  // 0: request as given, 1: double-fault replacement
  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);

  logic [VEC_W-1:0] cand_vec   [NCAND];
  logic [1:0]       cand_cls   [NCAND];
  logic             cand_bp    [NCAND];
  logic             cand_fits  [NCAND];
  logic             cand_push  [NCAND];
  logic             cand_rst   [NCAND];
  logic             cand_abort [NCAND];

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    if (g == 0) begin : g_req
      assign cand_vec[g] = req_vector;
      assign cand_cls[g] = req_class;
      assign cand_bp[g]  = req_code_bp;
    end else begin : g_df
      assign cand_vec[g] = DF_V;
      assign cand_cls[g] = CLS_EXCEPTION;
      assign cand_bp[g]  = 1'b0;
    end

    ixd_limit_chk #(.VEC_W(VEC_W), .LIM_W(LIM_W), .SHIFT(SHIFT)) u_chk (
      .vector (cand_vec[g]),
      .limit  (idt_limit),
      .fits   (cand_fits[g])
    );

    ixd_classify #(.VEC_W(VEC_W)) u_cls (
      .vector    (cand_vec[g]),
      .src_class (cand_cls[g]),
      .code_bp   (cand_bp[g]),
      .prot_mode (prot_mode),
      .push_err  (cand_push[g]),
      .restart   (cand_rst[g]),
      .is_abort  (cand_abort[g])
    );
  end

  ctl_state_e state;
  logic       accept;
  logic       pm_q;
  int         pick;

  assign req_ready  = (state == S_IDLE);
  assign disp_valid = (state == S_HOLD);
  assign accept     = req_valid && req_ready;

  always_comb begin
    pick = cand_fits[0] ? 0 : 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      disp_vector     <= '0;
      disp_push_err   <= 1'b0;
      disp_err_code   <= '0;
      disp_restart    <= 1'b0;
      disp_status     <= ST_FIRST;
      shutdown_strobe <= 1'b0;
      pm_q            <= 1'b0;
    end else begin
      shutdown_strobe <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (cand_fits[0] || cand_fits[1]) begin
            state         <= S_HOLD;
            pm_q          <= prot_mode;
            disp_vector   <= cand_vec[pick];
            disp_push_err <= cand_push[pick];
            disp_restart  <= cand_rst[pick];
            disp_err_code <= (cand_push[pick] && !cand_abort[pick]) ? req_err_code : '0;
            disp_status   <= cand_fits[0] ? ST_FIRST : ST_DOUBLE;
          end else begin
            state           <= S_HALT;
            disp_status     <= ST_SHUT;
            shutdown_strobe <= 1'b1;
          end
        end
        S_HOLD: if (disp_ready) state <= S_IDLE;
        default: state <= S_HALT;
      endcase
    end
  end

  // R1: result held under back-pressure
  p_hold_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_vector)
      && $stable(disp_err_code) && $stable(disp_push_err) && $stable(disp_restart)));

  // R3: a double-fault status always carries the double-fault vector as an abort
  p_double_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_status == ST_DOUBLE) |-> (disp_vector == DF_V && !disp_restart));

  // R4: shutdown strobe lasts one cycle
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_strobe |=> !shutdown_strobe);

  // R5: nothing is taken or presented after shutdown
  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_status == ST_SHUT) |-> (!req_ready && !disp_valid));

  // R7: real mode never pushes an error code
  p_real_nopush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !pm_q) |-> (!disp_push_err && disp_err_code == '0));

  // R6: double-fault vector pushes zero
  p_abort_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_vector == DF_V) |-> (disp_err_code == '0));
endmodule

// File: tb/ixd_dispatch_tb.sv
`timescale 1ns/1ps
module ixd_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] idt_limit = 16'h0;
  logic        prot_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vector = 8'h0;
  logic [1:0]  req_class = 2'b00;
  logic        req_code_bp = 1'b0;
  logic [15:0] req_err_code = 16'h0;
  logic        disp_valid;
  logic        disp_ready = 1'b0;
  logic [7:0]  disp_vector;
  logic        disp_push_err;
  logic [15:0] disp_err_code;
  logic        disp_restart;
  logic [1:0]  disp_status;
  logic        shutdown_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ixd_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .idt_limit(idt_limit), .prot_mode(prot_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_class(req_class), .req_code_bp(req_code_bp), .req_err_code(req_err_code),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_vector(disp_vector),
    .disp_push_err(disp_push_err), .disp_err_code(disp_err_code),
    .disp_restart(disp_restart), .disp_status(disp_status),
    .shutdown_strobe(shutdown_strobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit fits(input int v, input int lim);
    return (v * 8 + 7) <= lim;
  endfunction

  // reference model of the requirements
  function automatic void model(input int v, input int c, input bit bp, input bit pm,
                                input int lim, input int e, output bit shut,
                                output int ov, output bit op, output int oe,
                                output bit orst, output int ost);
    int  mv;
    int  mc;
    bit  exc;
    bit  codev;
    int  kind;  // 0 trap 1 fault 2 abort
    shut = 0;
    mv = v; mc = c; ost = 0;
    if (!fits(v, lim)) begin
      if (fits(8, lim)) begin mv = 8; mc = 2; ost = 1; end
      else begin shut = 1; ost = 2; end
    end
    exc = (mc >= 2);
    case (mv)
      1:       kind = bp ? 1 : 0;
      2, 3, 4: kind = 0;
      8, 18:   kind = 2;
      default: kind = 1;
    endcase
    if (!exc) kind = 0;
    codev = (mv == 8) || (mv >= 10 && mv <= 14) || (mv == 17);
    ov   = mv;
    op   = exc && codev && pm;
    oe   = (op && mv != 8) ? e : 0;
    orst = (kind == 1);
  endfunction

  task automatic do_req(input int v, input int c, input bit bp, input bit pm,
                        input int lim, input int e, input int hold, input string tag);
    bit shut; int ov; bit op; int oe; bit orst; int ost;
    model(v, c, bp, pm, lim, e, shut, ov, op, oe, orst, ost);
    @(negedge clk);
    idt_limit = 16'(lim); prot_mode = pm; req_vector = 8'(v); req_class = 2'(c);
    req_code_bp = bp; req_err_code = 16'(e); req_valid = 1'b1; disp_ready = 1'b0;
    chk(req_ready == 1'b1, {tag, " R1 ready before"}, int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!shut) begin
      chk(disp_valid == 1'b1, {tag, " R1 valid"}, int'(disp_valid), 1);
      chk(int'(disp_vector) == ov, {tag, " R2/R3 vector"}, int'(disp_vector), ov);
      chk(int'(disp_status) == ost, {tag, " R2/R3 status"}, int'(disp_status), ost);
      chk(disp_push_err == op, {tag, " R6/R7 push"}, int'(disp_push_err), int'(op));
      chk(int'(disp_err_code) == oe, {tag, " R6/R7 code"}, int'(disp_err_code), oe);
      chk(disp_restart == orst, {tag, " R8/R9 restart"}, int'(disp_restart), int'(orst));
      chk(shutdown_strobe == 1'b0, {tag, " R4 no strobe"}, int'(shutdown_strobe), 0);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(disp_valid && int'(disp_vector) == ov && int'(disp_err_code) == oe && !req_ready,
            {tag, " R1 hold"}, int'(disp_vector), ov);
      end
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
      chk(!disp_valid && req_ready, {tag, " R1 consumed"}, int'(disp_valid), 0);
    end else begin
      chk(shutdown_strobe == 1'b1, {tag, " R4 strobe"}, int'(shutdown_strobe), 1);
      chk(disp_valid == 1'b0, {tag, " R4 no result"}, int'(disp_valid), 0);
      chk(int'(disp_status) == 2, {tag, " R4 status"}, int'(disp_status), 2);
      @(negedge clk);
      chk(shutdown_strobe == 1'b0, {tag, " R4 pulse width"}, int'(shutdown_strobe), 0);
      chk(req_ready == 1'b0, {tag, " R5 ready low"}, int'(req_ready), 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!disp_valid && !shutdown_strobe, "R1 reset outputs", int'(disp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R10: boundary at limit 0x80
    do_req(15, 2, 0, 1, 16'h80, 16'h1234, 1, "R10 v15");
    do_req(16, 2, 0, 1, 16'h80, 16'h1234, 0, "R10 v16");
    do_req(200, 0, 0, 1, 16'h80, 16'h0, 0, "R3 soft overflow");
    // R9: vector 1 both causes
    do_req(1, 2, 1, 1, 16'h7FF, 16'h0, 0, "R9 code bp");
    do_req(1, 2, 0, 1, 16'h7FF, 16'h0, 0, "R9 trap");
    // R6/R7: error codes
    do_req(13, 3, 0, 1, 16'h7FF, 16'hBEEF, 2, "R6 gp");
    do_req(13, 2, 0, 0, 16'h7FF, 16'hBEEF, 0, "R7 gp real");
    do_req(8, 2, 0, 1, 16'h7FF, 16'hBEEF, 0, "R6 df direct");
    do_req(18, 2, 0, 1, 16'h7FF, 16'h55, 0, "R8 mc abort");
    do_req(14, 1, 0, 1, 16'h7FF, 16'h55, 0, "R6 ext no push");
    do_req(3, 2, 0, 1, 16'h7FF, 16'h0, 0, "R8 bp trap");

    // R4/R5: shutdown, ignored request, recovery
    do_req(20, 2, 0, 1, 16'd70, 16'h1, 0, "R4 triple");
    @(negedge clk);
    req_vector = 8'd0; req_class = 2'b10; idt_limit = 16'hFFFF; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!disp_valid && !req_ready && int'(disp_status) == 2, "R5 ignored", int'(disp_valid), 0);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R5 ready after reset", int'(req_ready), 1);
    do_req(0, 2, 0, 1, 16'hFFFF, 16'h0, 0, "R5 recovered");

    // random phase; limits keep vector 8 in range
    for (int i = 0; i < 400; i++) begin
      int v;
      v = ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 20)) : int'($urandom_range(0, 255));
      do_req(v, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             int'($urandom_range(71, 2100)), int'($urandom_range(0, 65535)),
             int'($urandom_range(0, 2)), "R2 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule